// File: doc/BRIEF.md
# Trace Packet Packer

This block sits at the end of a bus trace pipeline. Compressed trace items arrive with a payload, a payload length and a 4-bit type code. A one-cycle header stage turns each item into a packet: the type code followed by the significant payload bits. Packets are concatenated with no gaps into a bit accumulator. Each time the accumulator holds at least one full 32-bit word, that word goes out on a trace memory write port.

Each item carries the trace mode it was captured in. Ordinary packet headers do not say which mode they belong to. So when the mode changes, the block inserts a mode-change packet between the last packet of the old mode and the first packet of the new one. It pushes that packet in the same cycle as the last old-mode packet, so it never back-pressures its source. A flush request writes out any leftover bits as one zero-padded word.

Two buffer policies are supported. In post-trigger operation the memory fills once from address 0 and then stops. In pre-trigger operation writes wrap around and overwrite the oldest data. A small table records where every segment begins. When wrap-around overwrites the start of the oldest segment, that entry is retired and the oldest pointer moves on.

Top module: `trace_packer`

## Requirements
- R1: An accepted item becomes a packet of `item_len_i + 4` bits. Bits [3:0] hold the type code and the next `item_len_i` bits hold the low payload bits; payload bits at or above the length are discarded. Type code 0000 is reserved and lengths never exceed PAY_W.
- R2: Packets form one continuous stream, least significant bit first, in acceptance order. Each written memory word holds the next 32 stream bits, with word bit 0 being the earliest.
- R3: Words are written only while the accumulator holds at least 32 bits, at most one word per cycle, and they keep pace with the input. No partial word is written without a flush.
- R4: An accepted item whose mode differs from that of the previous accepted item produces a 7-bit mode-change packet. The first item after reset is compared against mode 0. The packet's bits [3:0] are 0000 and bits [6:4] hold the new mode. It sits in the stream directly before the new item's packet.
- R5: An item may be presented on every cycle. There is no ready signal, and at most 63 bits are ever buffered.
- R6: A flush with 1 to 31 bits buffered writes exactly one word: the leftover bits followed by zeros. A flush with nothing buffered writes nothing.
- R7: With `pretrig_i` low, words go to addresses 0, 1, 2 and so on. After DEPTH words, no further writes occur.
- R8: With `pretrig_i` high, the write address increments modulo DEPTH and writes never stop.
- R9: Head slot 0 holds address 0, offset 0 and is valid after reset. Each mode-change packet stores the word address (modulo DEPTH) and bit offset of its first bit into the next slot in round-robin order, starting at slot 1, and marks that slot valid.
- R10: With `pretrig_i` high, rewriting on a later lap the word that holds the oldest valid head clears that slot's valid bit and advances `head_oldest_o` by one.
- R11: Trace modes are encoded as follows: 0 full-signal cycle, 1 full-signal transaction, 2 bus-state cycle, 3 bus-state transaction, 4 master-state transaction.
- R12: During and right after reset, no write is issued and the head table is in the state given in R9 with `head_oldest_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pretrig_i | input | 1 | 1: wrap-around pre-trigger buffer, 0: fill-once post-trigger buffer |
| item_valid_i | input | 1 | Item present this cycle |
| item_hdr_i | input | 4 | Packet type code (nonzero) |
| item_len_i | input | LEN_W | Number of significant payload bits |
| item_data_i | input | PAY_W | Payload, LSB first |
| item_mode_i | input | 3 | Trace mode of the item |
| flush_i | input | 1 | Write out leftover bits |
| mem_we_o | output | 1 | Trace memory write strobe |
| mem_addr_o | output | log2(DEPTH) | Trace memory word address |
| mem_data_o | output | 32 | Trace memory write data |
| head_addr_o | output | NHEAD*log2(DEPTH) | Segment start word address per slot |
| head_off_o | output | NHEAD*5 | Segment start bit offset per slot |
| head_valid_o | output | NHEAD | Slot holds a live segment start |
| head_oldest_o | output | log2(NHEAD) | Slot of the oldest live segment |

## Verification
The assertions check several properties on every cycle. The buffered bit count stays below two words. Successive writes hit consecutive addresses, and a filled post-trigger buffer accepts nothing more. A recorded head appears in its slot one cycle later, and the oldest pointer moves when its word is overwritten. Legal item codes and lengths are also checked, along with zero padding on a flush. Only the bench scenarios can show that the stream content is right: bit order, payload masking, placement of mode-change packets between back-to-back and idle-separated items, the exact offsets recorded for segment heads, and retirement of heads after a full lap.

// File: rtl/tpk_pkg.sv
package tpk_pkg;
  localparam int WORD_W = 32;
  localparam int HDR_W  = 4;
  localparam int MODE_W = 3;
  localparam int MC_LEN = HDR_W + MODE_W;
  localparam int OFF_W  = $clog2(WORD_W);
  localparam logic [HDR_W-1:0] MC_HDR = '0;

  typedef enum logic [MODE_W-1:0] {
    TM_FULL_CYC = 3'd0,
    TM_FULL_TXN = 3'd1,
    TM_BUS_CYC  = 3'd2,
    TM_BUS_TXN  = 3'd3,
    TM_MST_TXN  = 3'd4
  } trace_mode_e;
endpackage

// File: rtl/tpk_hdr_stage.sv
module tpk_hdr_stage import tpk_pkg::*; #(
  parameter int PAY_W  = 21,
  parameter int LEN_W  = 5,
  parameter int PKT_W  = PAY_W + HDR_W,
  parameter int PLEN_W = $clog2(PKT_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              item_valid_i,
  input  logic [HDR_W-1:0]  item_hdr_i,
  input  logic [LEN_W-1:0]  item_len_i,
  input  logic [PAY_W-1:0]  item_data_i,
  input  logic [MODE_W-1:0] item_mode_i,
  output logic              pkt_valid_o,
  output logic [PKT_W-1:0]  pkt_bits_o,
  output logic [PLEN_W-1:0] pkt_len_o,
  output logic              mc_valid_o,
  output logic [MC_LEN-1:0] mc_bits_o
);
  logic [PAY_W-1:0]  len_mask;
  logic              v_q;
  logic [PKT_W-1:0]  pkt_q;
  logic [PLEN_W-1:0] len_q;
  logic [MODE_W-1:0] mode_q;

  always_comb begin
    len_mask = '0;
    for (int b = 0; b < PAY_W; b++)
      if (b < int'(item_len_i)) len_mask[b] = 1'b1;
  end

  // mode-change packet leaves with the last old-mode packet (held in stage)
  assign mc_valid_o = item_valid_i && (item_mode_i != mode_q);
  assign mc_bits_o  = {item_mode_i, MC_HDR};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q    <= 1'b0;
      pkt_q  <= '0;
      len_q  <= '0;
      mode_q <= TM_FULL_CYC;
    end else begin
      v_q <= item_valid_i;
      if (item_valid_i) begin
        pkt_q  <= {item_data_i & len_mask, item_hdr_i};
        len_q  <= PLEN_W'(item_len_i) + PLEN_W'(HDR_W);
        mode_q <= item_mode_i;
      end
    end
  end

  assign pkt_valid_o = v_q;
  assign pkt_bits_o  = pkt_q;
  assign pkt_len_o   = len_q;

  // R1
  hdr_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> $past(item_valid_i));
  // R1
  len_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    item_valid_i |-> (int'(item_len_i) <= PAY_W) && (item_hdr_i != MC_HDR));
  // R11
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    item_valid_i |-> item_mode_i <= TM_MST_TXN);
endmodule

// File: rtl/tpk_bit_fifo.sv
module tpk_bit_fifo import tpk_pkg::*; #(
  parameter int PKT_W  = 25,
  parameter int PLEN_W = 5,
  parameter int FIFO_W = 2 * WORD_W + PKT_W + MC_LEN,
  parameter int CNT_W  = $clog2(FIFO_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pkt_valid_i,
  input  logic [PKT_W-1:0]  pkt_bits_i,
  input  logic [PLEN_W-1:0] pkt_len_i,
  input  logic              mc_valid_i,
  input  logic [MC_LEN-1:0] mc_bits_i,
  input  logic              flush_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  mc_pos_o
);
  logic [FIFO_W-1:0] acc_q, acc_d, base, ins_a, ins_b;
  logic [CNT_W-1:0]  cnt_q, cnt_d, bcnt, l1;
  logic              pend_q, pop, flush_fire;

  always_comb begin
    pop        = cnt_q >= CNT_W'(WORD_W);
    flush_fire = pend_q && !pkt_valid_i && !mc_valid_i && !pop;
    base       = pop ? (acc_q >> WORD_W) : acc_q;
    bcnt       = pop ? cnt_q - CNT_W'(WORD_W) : cnt_q;
    l1         = pkt_valid_i ? CNT_W'(pkt_len_i) : '0;
    ins_a      = pkt_valid_i ? FIFO_W'(pkt_bits_i) : '0;
    ins_b      = mc_valid_i ? FIFO_W'(mc_bits_i) : '0;
    if (flush_fire) begin
      acc_d = '0;
      cnt_d = '0;
    end else begin
      acc_d = base | (ins_a << bcnt) | (ins_b << (bcnt + l1));
      cnt_d = bcnt + l1 + (mc_valid_i ? CNT_W'(MC_LEN) : '0);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      pend_q <= (pend_q && !flush_fire) || flush_i;
    end
  end

  assign word_valid_o = pop || (flush_fire && (cnt_q != '0));
  assign word_o       = acc_q[WORD_W-1:0];
  assign mc_pos_o     = bcnt + l1;

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(2 * WORD_W));
  // R6
  flush_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_fire && cnt_q != '0) |-> ((acc_q >> cnt_q) == '0));
endmodule

// File: rtl/tpk_head_table.sv
module tpk_head_table import tpk_pkg::*; #(
  parameter int NHEAD = 4,
  parameter int PTR_W = 5,
  parameter int IDX_W = $clog2(NHEAD)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   rec_i,
  input  logic [PTR_W-1:0]       rec_ptr_i,
  input  logic [OFF_W-1:0]       rec_off_i,
  input  logic                   wr_i,
  input  logic [PTR_W-1:0]       wr_ptr_i,
  input  logic                   wrap_i,
  output logic [NHEAD*PTR_W-1:0] ptr_o,
  output logic [NHEAD*OFF_W-1:0] off_o,
  output logic [NHEAD-1:0]       vld_o,
  output logic [IDX_W-1:0]       oldest_o
);
  logic [PTR_W-1:0] ptr_q [NHEAD];
  logic [OFF_W-1:0] off_q [NHEAD];
  logic [NHEAD-1:0] vld_q, vld_d;
  logic [IDX_W-1:0] oldest_q, oldest_d, next_q, next_d;
  logic             kill;

  // same word, previous lap
  assign kill = wrap_i && wr_i && vld_q[oldest_q]
             && (wr_ptr_i[PTR_W-2:0] == ptr_q[oldest_q][PTR_W-2:0])
             && (wr_ptr_i[PTR_W-1] != ptr_q[oldest_q][PTR_W-1]);

  always_comb begin
    vld_d    = vld_q;
    oldest_d = oldest_q;
    next_d   = next_q;
    if (kill) begin
      vld_d[oldest_q] = 1'b0;
      oldest_d        = oldest_q + 1'b1;
    end
    if (rec_i) begin
      if (vld_d[next_q] && (next_q == oldest_d)) oldest_d = oldest_d + 1'b1;
      vld_d[next_q] = 1'b1;
      next_d        = next_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NHEAD; k++) begin
        ptr_q[k] <= '0;
        off_q[k] <= '0;
      end
      vld_q    <= NHEAD'(1);
      oldest_q <= '0;
      next_q   <= IDX_W'(1);
    end else begin
      vld_q    <= vld_d;
      oldest_q <= oldest_d;
      next_q   <= next_d;
      if (rec_i) begin
        ptr_q[next_q] <= rec_ptr_i;
        off_q[next_q] <= rec_off_i;
      end
    end
  end

  for (genvar g = 0; g < NHEAD; g++) begin : g_flat
    assign ptr_o[g*PTR_W +: PTR_W] = ptr_q[g];
    assign off_o[g*OFF_W +: OFF_W] = off_q[g];
  end
  assign vld_o    = vld_q;
  assign oldest_o = oldest_q;

  // R9
  head_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_i |=> vld_q[$past(next_q)] && (ptr_q[$past(next_q)] == $past(rec_ptr_i)));
  // R10
  head_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill |=> oldest_q != $past(oldest_q));
endmodule

// File: rtl/trace_packer.sv
module trace_packer import tpk_pkg::*; #(
  parameter int PAY_W = 21,
  parameter int LEN_W = 5,
  parameter int DEPTH = 16,
  parameter int NHEAD = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               pretrig_i,
  input  logic                               item_valid_i,
  input  logic [3:0]                         item_hdr_i,
  input  logic [LEN_W-1:0]                   item_len_i,
  input  logic [PAY_W-1:0]                   item_data_i,
  input  logic [2:0]                         item_mode_i,
  input  logic                               flush_i,
  output logic                               mem_we_o,
  output logic [$clog2(DEPTH)-1:0]           mem_addr_o,
  output logic [31:0]                        mem_data_o,
  output logic [NHEAD*$clog2(DEPTH)-1:0]     head_addr_o,
  output logic [NHEAD*OFF_W-1:0]             head_off_o,
  output logic [NHEAD-1:0]                   head_valid_o,
  output logic [$clog2(NHEAD)-1:0]           head_oldest_o
);
  localparam int AW     = $clog2(DEPTH);
  localparam int PTR_W  = AW + 1;
  localparam int PKT_W  = PAY_W + HDR_W;
  localparam int PLEN_W = $clog2(PKT_W + 1);
  localparam int FIFO_W = 2 * WORD_W + PKT_W + MC_LEN;
  localparam int CNT_W  = $clog2(FIFO_W + 1);

  logic              pkt_valid, mc_valid, word_valid, full, we;
  logic [PKT_W-1:0]  pkt_bits;
  logic [PLEN_W-1:0] pkt_len;
  logic [MC_LEN-1:0] mc_bits;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  mc_pos;
  logic [PTR_W-1:0]  wr_ptr_q, rec_ptr;
  logic [NHEAD*PTR_W-1:0] head_ptr;

  tpk_hdr_stage #(.PAY_W(PAY_W), .LEN_W(LEN_W), .PKT_W(PKT_W), .PLEN_W(PLEN_W)) u_hdr (
    .clk_i, .rst_ni, .item_valid_i, .item_hdr_i, .item_len_i, .item_data_i, .item_mode_i,
    .pkt_valid_o(pkt_valid), .pkt_bits_o(pkt_bits), .pkt_len_o(pkt_len),
    .mc_valid_o(mc_valid), .mc_bits_o(mc_bits)
  );

  tpk_bit_fifo #(.PKT_W(PKT_W), .PLEN_W(PLEN_W), .FIFO_W(FIFO_W), .CNT_W(CNT_W)) u_fifo (
    .clk_i, .rst_ni,
    .pkt_valid_i(pkt_valid), .pkt_bits_i(pkt_bits), .pkt_len_i(pkt_len),
    .mc_valid_i(mc_valid), .mc_bits_i(mc_bits), .flush_i,
    .word_valid_o(word_valid), .word_o(word), .mc_pos_o(mc_pos)
  );

  assign full    = !pretrig_i && (wr_ptr_q == PTR_W'(DEPTH));
  assign we      = word_valid && !full;
  assign rec_ptr = wr_ptr_q + PTR_W'(we) + PTR_W'(mc_pos >> OFF_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q   <= '0;
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
    end else begin
      mem_we_o <= we;
      if (we) begin
        mem_addr_o <= wr_ptr_q[AW-1:0];
        mem_data_o <= word;
        wr_ptr_q   <= wr_ptr_q + 1'b1;
      end
    end
  end

  tpk_head_table #(.NHEAD(NHEAD), .PTR_W(PTR_W)) u_heads (
    .clk_i, .rst_ni,
    .rec_i(mc_valid), .rec_ptr_i(rec_ptr), .rec_off_i(mc_pos[OFF_W-1:0]),
    .wr_i(we), .wr_ptr_i(wr_ptr_q), .wrap_i(pretrig_i),
    .ptr_o(head_ptr), .off_o(head_off_o), .vld_o(head_valid_o), .oldest_o(head_oldest_o)
  );

  for (genvar g = 0; g < NHEAD; g++) begin : g_haddr
    assign head_addr_o[g*AW +: AW] = head_ptr[g*PTR_W +: AW];
  end

  // R7
  post_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pretrig_i && wr_ptr_q == PTR_W'(DEPTH)) |=> !mem_we_o);
  // R8
  addr_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o || (mem_addr_o == AW'($past(mem_addr_o) + 1'b1)));
endmodule

// File: tb/trace_packer_tb_top.sv
`timescale 1ns/1ps
module trace_packer_tb_top;
  localparam int PAY_W = 21;
  localparam int LEN_W = 5;
  localparam int DEPTH = 16;
  localparam int NHEAD = 4;
  localparam int AW    = 4;
  localparam int NVEC  = 16;

  // [33] valid [32:30] mode [29:26] hdr [25:21] len [20:0] data
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b1, 3'd0, 4'h1, 5'd8,  21'h0000A5},
    {1'b1, 3'd0, 4'h2, 5'd21, 21'h1FFFFF},
    {1'b1, 3'd0, 4'h3, 5'd3,  21'h1FFFF5},
    {1'b1, 3'd1, 4'h4, 5'd12, 21'h000ABC},
    {1'b1, 3'd1, 4'h5, 5'd0,  21'h001234},
    {1'b1, 3'd1, 4'h6, 5'd17, 21'h01E0F1},
    {1'b0, 3'd0, 4'h0, 5'd0,  21'h000000},
    {1'b0, 3'd0, 4'h0, 5'd0,  21'h000000},
    {1'b1, 3'd4, 4'hF, 5'd21, 21'h155555},
    {1'b1, 3'd4, 4'h7, 5'd9,  21'h0001FF},
    {1'b1, 3'd2, 4'h8, 5'd21, 21'h0AAAAA},
    {1'b1, 3'd2, 4'h9, 5'd1,  21'h000001},
    {1'b0, 3'd0, 4'h0, 5'd0,  21'h000000},
    {1'b1, 3'd2, 4'hA, 5'd16, 21'h00BEEF},
    {1'b1, 3'd2, 4'hB, 5'd21, 21'h012345},
    {1'b1, 3'd2, 4'hC, 5'd5,  21'h00001F}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pretrig_i = 1'b0;
  logic item_valid_i = 1'b0;
  logic [3:0] item_hdr_i = '0;
  logic [LEN_W-1:0] item_len_i = '0;
  logic [PAY_W-1:0] item_data_i = '0;
  logic [2:0] item_mode_i = '0;
  logic flush_i = 1'b0;
  logic mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_data_o;
  logic [NHEAD*AW-1:0] head_addr_o;
  logic [NHEAD*5-1:0] head_off_o;
  logic [NHEAD-1:0] head_valid_o;
  logic [1:0] head_oldest_o;

  trace_packer #(.PAY_W(PAY_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .NHEAD(NHEAD)) dut_i (.*);

  always #10 clk_i = ~clk_i;

  logic exp_bits [4096];
  int nbits, nw, nchk, nerr, n_mc, cyc;
  int exp_hpos [NHEAD];
  logic [2:0] last_mode;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_add(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) exp_bits[nbits + i] = v[i];
    nbits += n;
  endtask

  task automatic do_reset(input logic pre);
    @(negedge clk_i);
    rst_ni = 1'b0; pretrig_i = pre; item_valid_i = 1'b0; flush_i = 1'b0;
    for (int i = 0; i < 4096; i++) exp_bits[i] = 1'b0;
    nbits = 0; nw = 0; n_mc = 0; last_mode = 3'd0;
    exp_hpos[0] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic send(input logic v, input logic [2:0] m, input logic [3:0] h,
                      input logic [4:0] l, input logic [20:0] d);
    logic [31:0] pk;
    @(negedge clk_i);
    item_valid_i = v; item_mode_i = m; item_hdr_i = h; item_len_i = l; item_data_i = d;
    if (v) begin
      if (m != last_mode) begin
        exp_hpos[(1 + n_mc) % NHEAD] = nbits;
        n_mc++;
        model_add({25'd0, m, 4'b0000}, 7);
        last_mode = m;
      end
      pk = '0;
      for (int b = 0; b < int'(l); b++) pk[b + 4] = d[b];
      pk[3:0] = h;
      model_add(pk, int'(l) + 4);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk_i);
      item_valid_i = 1'b0; flush_i = 1'b0;
    end
  endtask

  task automatic pulse_flush();
    @(negedge clk_i);
    item_valid_i = 1'b0; flush_i = 1'b1;
    @(negedge clk_i);
    flush_i = 1'b0;
  endtask

  task automatic check_head(input int k, input string req);
    check(head_valid_o[k] == 1'b1, req, $sformatf("head %0d valid", k), head_valid_o[k], 1);
    check(head_addr_o[k*AW +: AW] == AW'((exp_hpos[k] / 32) % DEPTH), req,
          $sformatf("head %0d addr", k), head_addr_o[k*AW +: AW], (exp_hpos[k] / 32) % DEPTH);
    check(head_off_o[k*5 +: 5] == 5'(exp_hpos[k] % 32), req,
          $sformatf("head %0d off", k), head_off_o[k*5 +: 5], exp_hpos[k] % 32);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  // write monitor: R2 R4 R11 content, R7 R8 address order
  always @(negedge clk_i) begin
    if (rst_ni && mem_we_o) begin
      logic [31:0] ew;
      for (int i = 0; i < 32; i++) ew[i] = exp_bits[nw * 32 + i];
      check(mem_data_o == ew, "R2 R4 R11", $sformatf("word %0d", nw), mem_data_o, ew);
      check(mem_addr_o == AW'(nw % DEPTH), "R8", $sformatf("addr of word %0d", nw),
            mem_addr_o, nw % DEPTH);
      nw++;
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    nchk = 0; nerr = 0; cyc = 0;

    // R12 reset state
    do_reset(1'b0);
    @(negedge clk_i);
    check(mem_we_o == 1'b0, "R12", "no write after reset", mem_we_o, 0);
    check(head_valid_o == 4'b0001, "R12", "head valid after reset", head_valid_o, 1);
    check(head_oldest_o == 2'd0, "R12", "oldest after reset", head_oldest_o, 0);
    check(head_addr_o[AW-1:0] == '0 && head_off_o[4:0] == '0, "R9", "slot 0 origin",
          {head_addr_o[AW-1:0], head_off_o[4:0]}, 0);

    // vector walk: R1 R4 R5 (back-to-back, idle gaps, masking)
    for (int v = 0; v < NVEC; v++)
      send(VEC[v][33], VEC[v][32:30], VEC[v][29:26], VEC[v][25:21], VEC[v][20:0]);
    idle(4);
    check(nw == nbits / 32, "R3", "full words kept pace", nw, nbits / 32);
    pulse_flush();
    idle(6);
    check(nw == (nbits + 31) / 32, "R6", "flush wrote tail", nw, (nbits + 31) / 32);
    check(n_mc == 3, "R4", "mode changes in table", n_mc, 3);
    for (int k = 1; k <= 3; k++) check_head(k, "R9");
    check(head_oldest_o == 2'd0, "R9", "oldest unchanged", head_oldest_o, 0);

    // R3 R6: short tail and empty flush
    do_reset(1'b0);
    send(1'b1, 3'd0, 4'h3, 5'd5, 21'h1FFFFF);
    send(1'b1, 3'd0, 4'h6, 5'd10, 21'h0002AA);
    send(1'b1, 3'd0, 4'h9, 5'd0, 21'h0000FF);
    idle(5);
    check(nw == 0, "R3", "no partial word", nw, 0);
    pulse_flush();
    idle(6);
    check(nw == 1, "R6", "one padded word", nw, 1);
    pulse_flush();
    idle(6);
    check(nw == 1, "R6", "empty flush writes nothing", nw, 1);

    // R7 post-trigger fill-once, R5 max-length every cycle
    do_reset(1'b0);
    for (int i = 0; i < 30; i++) send(1'b1, 3'd0, 4'(1 + i % 15), 5'd21, 21'(i * 7919));
    idle(6);
    pulse_flush();
    idle(6);
    check(nw == DEPTH, "R7", "writes stop at depth", nw, DEPTH);

    // R8 R10 pre-trigger wrap and head retirement
    do_reset(1'b1);
    for (int i = 0; i < 5; i++) send(1'b1, 3'd0, 4'h5, 5'd21, 21'(i * 104729));
    for (int i = 0; i < 17; i++) send(1'b1, 3'd3, 4'hA, 5'd21, 21'(i * 31337));
    idle(6);
    check(nw == 17, "R8", "writes continue past depth", nw, 17);
    check(head_valid_o[0] == 1'b0, "R10", "slot 0 retired", head_valid_o[0], 0);
    check(head_oldest_o == 2'd1, "R10", "oldest moved to 1", head_oldest_o, 1);
    check_head(1, "R9");
    for (int i = 0; i < 18; i++) send(1'b1, 3'd3, 4'hB, 5'd21, 21'(i * 65537));
    idle(6);
    check(nw == 31, "R8", "word count after second lap", nw, 31);
    check(head_valid_o[1] == 1'b0, "R10", "slot 1 retired", head_valid_o[1], 0);
    check(head_oldest_o == 2'd2, "R10", "oldest moved to 2", head_oldest_o, 2);

    finish_run();
  end
endmodule